// File: doc/BRIEF.md
# Cascadable Serial Configuration Stream Reader

This block is the readout side of a serial configuration store that feeds a programmable logic device during a master-serial load. A word-wide internal array is walked by a word address counter and a bit counter. The current bit is presented on a data output with a separate drive-enable flag, which models a three-state pin. Each word goes out most significant bit first. A bit counts as consumed on a clock edge at which it was being driven and the part is still selected.

Two inputs gate the readout. The first is an active-low chip select. The second is a combined pin: low means reset, high means output enable. The address space can be confined to one of four equal pages, which lets one array hold several bitstreams. At the end of the active range the block drops its chain-enable output, so that the next store in a daisy chain can take over the data line. A serial-enable input set low places the block in programming mode: the readout is frozen and nothing is driven. After a power-up reset a ready flag stays low for a programmable number of cycles. The array is loaded through a plain synchronous write port.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `oe_rst_i` is low and `ser_en_i` is high, each clock edge reloads the counters to the start of the range and clears the end flag. `data_oe_o` is 0 on the following cycle whatever the level of `ce_n_i`.
- R2: With `ser_en_i`, `oe_rst_i` and `ready_o` high and `ce_n_i` low, `data_oe_o` goes to 1 one cycle after that condition is first sampled. `data_o` then shows bit WORD_W-1 (the MSB) of the first word. A driven bit advances to the next lower bit at each edge that keeps the condition true. After bit 0 the next word follows.
- R3: With `ser_en_i` high and `ce_n_i` high, both counters hold and `data_oe_o` is 0 one cycle later. `standby_o` is 1 one cycle later. A bit shown but not consumed is shown again when `ce_n_i` returns low.
- R4: When a reload happens with `page_en_i` high, the read covers words `page_sel_i`*DEPTH/4 up to (`page_sel_i`+1)*DEPTH/4-1. The page pins are sampled at the reload, and `page_sel_i` forms the top two address bits.
- R5: When a reload happens with `page_en_i` low, the read covers words 0 up to DEPTH-1.
- R6: One cycle after the last bit of the range is consumed, `data_oe_o` is 0 and `ceo_n_o` is 0. The counters stop there and do not wrap.
- R7: Once the end is reached, `ceo_n_o` follows `ce_n_i` with one cycle of delay. After `oe_rst_i` is sampled low, `ceo_n_o` stays 1 until the end of the range is reached again.
- R8: While `ser_en_i` is low, `ce_n_i`, `oe_rst_i`, `page_en_i` and `page_sel_i` have no effect. The counters hold, and `data_oe_o`, `standby_o` and `ceo_n_o` read 0, 0 and 1 one cycle later. On return the read resumes at the bit that was pending.
- R9: After `rst`, `ready_o` is 0 for exactly RDY_CYCLES clock edges and is then 1. Nothing is driven while it is 0. The counters start at the beginning of the range.
- R10: If a reload and the final advance fall on the same edge, the reload wins. `ceo_n_o` stays 1 and the read restarts at the range start.
- R11: A write with `wr_en_i` high stores `wr_data_i` at word `wr_addr_i`. That value is what a later read of that word shifts out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock; one bit per rising edge |
| rst | input | 1 | Synchronous active-high power-up reset |
| ser_en_i | input | 1 | 1 = readout mode, 0 = programming mode |
| ce_n_i | input | 1 | Active-low chip select |
| oe_rst_i | input | 1 | Low = counter reset, high = output enable |
| page_en_i | input | 1 | 1 = confine the read to one quarter of the array |
| page_sel_i | input | PAGE_BITS | Quarter selected when paging is on |
| wr_en_i | input | 1 | Array write strobe |
| wr_addr_i | input | ADDR_W | Array write word address |
| wr_data_i | input | WORD_W | Array write data |
| data_o | output | 1 | Serial data bit (0 when not driven) |
| data_oe_o | output | 1 | Drive enable of the serial data |
| ceo_n_o | output | 1 | Active-low chain enable to the next store |
| ready_o | output | 1 | Power-up reset complete |
| standby_o | output | 1 | Selected off in readout mode |

## Verification
The sharpest case is a counter reload landing on the same clock edge as the final advance that would set the end flag and drop the chain enable. The bench provokes it by reading a page to its very last driven bit and pulling `oe_rst_i` low in that same cycle. It then expects `ceo_n_o` to stay high, `data_oe_o` to go low, and the next read to start again at the MSB of the page's first word. A second overlap is a deselect or a mode change in the cycle where a bit is pending; the bench checks that the same bit reappears rather than being skipped.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  // Next position of the read pointer, computed in one place
  typedef struct packed {
    logic reload;
    logic step;
    logic wrap;
    logic at_last;
  } seq_ctl_t;

endpackage

// File: rtl/cfg_ready_gen.sv
module cfg_ready_gen #(
  parameter int RDY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic ready_o
);
  localparam int CW = $clog2(RDY_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      cnt_q <= cnt_q + 1'b1;
      rdy_q <= (cnt_q == CW'(RDY_CYCLES - 1));
    end
  end

  assign ready_o = rdy_q;

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> rdy_q); // R9
endmodule

// File: rtl/cfg_page_map.sv
module cfg_page_map #(
  parameter int ADDR_W    = 6,
  parameter int PAGE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic                 page_en_i,
  input  logic [PAGE_BITS-1:0] page_sel_i,
  output logic [ADDR_W-1:0]    base_o,
  output logic [ADDR_W-1:0]    last_o
);
  localparam int OFF_W = ADDR_W - PAGE_BITS;

  logic                 en_q;
  logic [PAGE_BITS-1:0] sel_q;

  // Page pins are captured whenever the counters are reloaded
  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      en_q  <= page_en_i;
      sel_q <= page_sel_i;
    end
  end

  assign base_o = page_en_i ? {page_sel_i, {OFF_W{1'b0}}} : '0;
  assign last_o = en_q      ? {sel_q, {OFF_W{1'b1}}}      : '1;
endmodule

// File: rtl/cfg_word_ram.sv
module cfg_word_ram #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [WORD_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [WORD_W-1:0] rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
    rd_q <= mem[ra_i];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
  import cfg_stream_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ser_en_i,
  input  logic                      ce_n_i,
  input  logic                      oe_rst_i,
  input  logic                      ready_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [ADDR_W-1:0]         last_i,
  output logic [ADDR_W-1:0]         addr_next_o,
  output logic [$clog2(WORD_W)-1:0] bit_o,
  output logic                      drv_o,
  output logic                      ceo_n_o,
  output logic                      standby_o
);
  localparam int BW = $clog2(WORD_W);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic              end_q, end_d;
  logic              drv_q, drv_d;
  logic              ceo_n_q, ceo_n_d;
  logic              stby_q, stby_d;
  logic              run;
  seq_ctl_t          ctl;

  assign run         = ser_en_i && oe_rst_i && !ce_n_i;
  assign ctl.reload  = ser_en_i && !oe_rst_i;
  assign ctl.step    = run && drv_q && !end_q;
  assign ctl.wrap    = (bit_q == BW'(WORD_W - 1));
  assign ctl.at_last = (addr_q == last_i);

  always_comb begin
    addr_d = addr_q;
    bit_d  = bit_q;
    end_d  = end_q;
    if (ctl.reload) begin
      addr_d = base_i;
      bit_d  = '0;
      end_d  = 1'b0;
    end else if (ctl.step) begin
      if (!ctl.wrap) begin
        bit_d = bit_q + 1'b1;
      end else if (ctl.at_last) begin
        end_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
        bit_d  = '0;
      end
    end
    drv_d   = run && ready_i && !end_d;
    ceo_n_d = !(ser_en_i && end_d && !ce_n_i);
    stby_d  = ser_en_i && ce_n_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= base_i;
      bit_q   <= '0;
      end_q   <= 1'b0;
      drv_q   <= 1'b0;
      ceo_n_q <= 1'b1;
      stby_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      bit_q   <= bit_d;
      end_q   <= end_d;
      drv_q   <= drv_d;
      ceo_n_q <= ceo_n_d;
      stby_q  <= stby_d;
    end
  end

  assign addr_next_o = addr_d;
  assign bit_o       = bit_q;
  assign drv_o       = drv_q;
  assign ceo_n_o     = ceo_n_q;
  assign standby_o   = stby_q;

  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ser_en_i && !oe_rst_i) |=> (bit_q == '0 && !end_q && !drv_q)); // R1
  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ser_en_i && oe_rst_i && ce_n_i) |=> ($stable(bit_q) && $stable(addr_q) && !drv_q)); // R3
  AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !ser_en_i |=> ($stable(bit_q) && $stable(addr_q) && !drv_q && ceo_n_q)); // R8
  AST_END_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (end_q && oe_rst_i) |=> (end_q && $stable(addr_q))); // R6
  AST_NOT_READY_SILENT: assert property (@(posedge clk) disable iff (rst)
    !ready_i |=> !drv_q); // R9
  AST_CEO_NEEDS_END: assert property (@(posedge clk) disable iff (rst)
    !ceo_n_q |-> end_q); // R7
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
  parameter int ADDR_W     = 6,
  parameter int WORD_W     = 8,
  parameter int PAGE_BITS  = 2,
  parameter int RDY_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_en_i,
  input  logic                 ce_n_i,
  input  logic                 oe_rst_i,
  input  logic                 page_en_i,
  input  logic [PAGE_BITS-1:0] page_sel_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  output logic                 data_o,
  output logic                 data_oe_o,
  output logic                 ceo_n_o,
  output logic                 ready_o,
  output logic                 standby_o
);
  localparam int BW = $clog2(WORD_W);

  logic              ready;
  logic [ADDR_W-1:0] base, last, addr_next;
  logic [BW-1:0]     bit_pos, bit_idx;
  logic [WORD_W-1:0] word;
  logic              drv;

  cfg_ready_gen #(.RDY_CYCLES(RDY_CYCLES)) u_ready (
    .clk(clk), .rst(rst), .ready_o(ready)
  );

  cfg_page_map #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_page (
    .clk(clk), .rst(rst),
    .load_i(ser_en_i && !oe_rst_i),
    .page_en_i(page_en_i), .page_sel_i(page_sel_i),
    .base_o(base), .last_o(last)
  );

  cfg_read_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst),
    .ser_en_i(ser_en_i), .ce_n_i(ce_n_i), .oe_rst_i(oe_rst_i),
    .ready_i(ready), .base_i(base), .last_i(last),
    .addr_next_o(addr_next), .bit_o(bit_pos), .drv_o(drv),
    .ceo_n_o(ceo_n_o), .standby_o(standby_o)
  );

  // Read port is addressed with the next pointer so the word lines up
  cfg_word_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .we_i(wr_en_i), .wa_i(wr_addr_i), .wd_i(wr_data_i),
    .ra_i(addr_next), .rd_o(word)
  );

  assign bit_idx   = BW'(WORD_W - 1) - bit_pos;
  assign data_o    = drv && word[bit_idx];
  assign data_oe_o = drv;
  assign ready_o   = ready;

  AST_CHAIN_SILENT: assert property (@(posedge clk) disable iff (rst)
    !ceo_n_o |-> !data_oe_o); // R6
  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (ce_n_i || !oe_rst_i) |=> !data_oe_o); // R1
endmodule

// File: tb/cfg_stream_reader_bench.sv
module cfg_stream_reader_bench;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 8;
  localparam int PB     = 2;
  localparam int RDY    = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PW     = DEPTH / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_en = 1'b1, ce_n = 1'b1, oe = 1'b1, pen = 1'b0;
  logic [PB-1:0] psel = '0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic data, data_oe, ceo_n, ready, standby;

  logic [WORD_W-1:0] model [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_stream_reader #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAGE_BITS(PB),
                      .RDY_CYCLES(RDY)) u_cfg_stream_reader (
    .clk(clk), .rst(rst), .ser_en_i(ser_en), .ce_n_i(ce_n), .oe_rst_i(oe),
    .page_en_i(pen), .page_sel_i(psel), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .data_o(data), .data_oe_o(data_oe), .ceo_n_o(ceo_n),
    .ready_o(ready), .standby_o(standby)
  );

  function automatic logic exp_bit(input int idx);
    return model[idx / WORD_W][WORD_W - 1 - (idx % WORD_W)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_oe();
    oe = 1'b0;
    tick();
    oe = 1'b1;
  endtask

  // Select and stream n bits starting at absolute bit index first
  task automatic read_bits(input int first, input int n, input string req);
    int bad;
    bad = 0;
    ce_n = 1'b0;
    oe   = 1'b1;
    for (int k = 0; k < n; k++) begin
      tick();
      if (data_oe !== 1'b1 || data !== exp_bit(first + k)) bad++;
      if (bad == 1 && (data_oe !== 1'b1 || data !== exp_bit(first + k))) begin
        chk(1'b0, req, int'(data), int'(exp_bit(first + k)));
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ready == 1'b0, "R9 ready low after reset", int'(ready), 0);
    chk(data_oe == 1'b0 && ceo_n == 1'b1, "R9 idle outputs", int'(data_oe), 0);
    ce_n = 1'b0;
    repeat (RDY - 1) tick();
    chk(ready == 1'b0 && data_oe == 1'b0, "R9 not ready, no drive", int'(ready), 0);
    tick();
    chk(ready == 1'b1, "R9 ready after RDY_CYCLES", int'(ready), 1);
    ce_n = 1'b1;
    tick();
  endtask

  task automatic load_all();
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = WORD_W'((i * 37 + 11) ^ (i << 3));
      wr_en = 1'b1; wr_addr = ADDR_W'(i); wr_data = model[i];
      tick();
    end
    wr_en = 1'b0;
  endtask

  task automatic t_full();
    pen = 1'b0;
    pulse_oe();
    read_bits(0, DEPTH * WORD_W, "R2 R5 full array stream");
    tick();
    chk(data_oe == 1'b0, "R6 stop driving after last bit", int'(data_oe), 0);
    chk(ceo_n == 1'b0, "R6 chain enable low at end", int'(ceo_n), 0);
    repeat (3) tick();
    chk(data_oe == 1'b0 && ceo_n == 1'b0, "R6 no wrap after end", int'(data_oe), 0);
  endtask

  task automatic t_ceo();
    ce_n = 1'b1; tick();
    chk(ceo_n == 1'b1, "R7 follows CE high", int'(ceo_n), 1);
    ce_n = 1'b0; tick();
    chk(ceo_n == 1'b0 && data_oe == 1'b0, "R7 follows CE low", int'(ceo_n), 0);
    oe = 1'b0; tick();
    chk(ceo_n == 1'b1, "R7 high after OE low", int'(ceo_n), 1);
    chk(data_oe == 1'b0, "R1 no drive with CE low", int'(data_oe), 0);
    tick();
    chk(ceo_n == 1'b1, "R7 stays high", int'(ceo_n), 1);
    read_bits(0, 3, "R1 restart at first bit");
    chk(ceo_n == 1'b1, "R7 high while re-reading", int'(ceo_n), 1);
    ce_n = 1'b1; tick();
  endtask

  task automatic t_page(input int sel);
    pen = 1'b1; psel = PB'(sel);
    pulse_oe();
    pen = 1'b0; psel = '0;   // pins after the reload must not matter
    read_bits(sel * PW * WORD_W, PW * WORD_W, $sformatf("R4 page %0d stream", sel));
    tick();
    chk(data_oe == 1'b0 && ceo_n == 1'b0, "R4 end at page boundary", int'(ceo_n), 0);
    ce_n = 1'b1; tick();
  endtask

  task automatic t_standby();
    pen = 1'b0;
    pulse_oe();
    read_bits(0, 10, "R2 partial stream");
    ce_n = 1'b1;
    tick();
    chk(data_oe == 1'b0 && standby == 1'b1, "R3 standby on CE high", int'(standby), 1);
    repeat (3) tick();
    chk(data_oe == 1'b0, "R3 still silent", int'(data_oe), 0);
    read_bits(9, 4, "R3 resume at pending bit");
    ce_n = 1'b1;
    oe = 1'b0; tick();
    chk(data_oe == 1'b0, "R1 silent during reset", int'(data_oe), 0);
    oe = 1'b1;
    read_bits(0, 2, "R1 reset with CE high restarts");
    ce_n = 1'b1; tick();
  endtask

  task automatic t_prog();
    pen = 1'b0;
    pulse_oe();
    read_bits(0, 5, "R8 prefix");
    ser_en = 1'b0;
    tick();
    chk(data_oe == 1'b0 && standby == 1'b0 && ceo_n == 1'b1,
        "R8 programming mode silent", int'(data_oe), 0);
    ce_n = 1'b1; pen = 1'b1; psel = 2'd2; oe = 1'b0; tick();
    ce_n = 1'b0; oe = 1'b1; tick();
    oe = 1'b0; tick();
    chk(data_oe == 1'b0 && ceo_n == 1'b1, "R8 pins ignored", int'(data_oe), 0);
    pen = 1'b0; psel = '0; oe = 1'b1; ce_n = 1'b1; ser_en = 1'b1;
    tick();
    read_bits(4, 4, "R8 resume at pending bit");
    ce_n = 1'b1; tick();
  endtask

  task automatic t_collide();
    pen = 1'b1; psel = 2'd0;
    pulse_oe();
    read_bits(0, PW * WORD_W, "R10 page 0 up to last bit");
    oe = 1'b0;
    tick();
    chk(ceo_n == 1'b1, "R10 reload beats end", int'(ceo_n), 1);
    chk(data_oe == 1'b0, "R10 no drive", int'(data_oe), 0);
    read_bits(0, 3, "R10 restart at page start");
    ce_n = 1'b1; tick();
  endtask

  task automatic t_rewrite();
    model[1] = 8'hA5;
    wr_en = 1'b1; wr_addr = 6'd1; wr_data = 8'hA5;
    tick();
    wr_en = 1'b0;
    pen = 1'b0;
    pulse_oe();
    read_bits(0, 2 * WORD_W, "R11 rewritten word");
    ce_n = 1'b1; tick();
  endtask

  initial begin
    t_reset();
    load_all();
    t_full();
    t_ceo();
    t_page(3);
    t_page(1);
    t_standby();
    t_prog();
    t_collide();
    t_rewrite();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule